// File: doc/BRIEF.md
# Hardware Real-Time Task Scheduler

This block is a scheduling coprocessor that sits next to a CPU. The CPU drives it through a narrow command port in the style of a custom instruction. Four commands exist: run (dispatch), configure, add task and preempt check. No memory-mapped bus is involved.

The block keeps two small sorted register queues. The ready queue is ordered by priority, with the highest first. The sleep queue is ordered by wake-up time, with the earliest first. A free-running tick timer starts on the first run command. The number of system clocks per tick can be changed while the block is running. When a sleeping task's wake time arrives, the hardware moves it into the ready queue on its own, one task per cycle.

A run command returns the identifier of the best ready task and records its priority as the running task. A preempt check returns a single flag that tells the CPU whether a waiting task outranks the one it is running. Context switching stays in software.

Top module: `task_sched_core`

## Requirements
- R1: After reset, `resp_valid` is 0, `cmd_ready` is 1, `now_ticks` is 0 and both queues are empty.
- R2: `now_ticks` holds at 0 until the first accepted run command. After that it rises by exactly one every D clocks. D is the clocks-per-tick value, which resets to DEF_DIV.
- R3: A configure command (`cmd_op`=1) loads D from `cmd_arg` and restarts the tick prescaler at the accepting edge. A value of 0 acts as 1. The command is accepted at any time, including while the timer runs.
- R4: An add-task command (`cmd_op`=2) with `cmd_arg`=0 puts the task into the ready queue. A larger `cmd_prio` value means a higher priority. Tasks of equal priority leave in arrival order.
- R5: An add-task command with `cmd_arg`>0 puts the task into the sleep queue with wake time `now_ticks`+`cmd_arg`. When the sleep head's wake time is at or below `now_ticks`, the head moves to the ready queue, one task per cycle, earliest wake first and arrival order on ties. `cmd_ready` is 0 in every cycle such a move takes place.
- R6: A run command (`cmd_op`=0) is answered one cycle after acceptance. The answer carries the ready head's id in `resp_id`, and the block removes that task and records its priority as running. If the ready queue is empty, `resp_err` is 1, `resp_id` is 0 and no task is marked running.
- R7: A preempt check (`cmd_op`=3) is answered one cycle after acceptance. `resp_flag` is 1 exactly when the ready queue is non-empty and either no task is running or the ready head's priority is strictly above the running priority.
- R8: An add-task command aimed at a full queue is rejected. `resp_err` is 1, and the queue contents stay unchanged.
- R9: Every accepted command produces exactly one `resp_valid` pulse, in the next cycle, and `resp_valid` is 0 otherwise. `resp_flag` and `resp_err` are 0 in responses where they do not apply.
- R10: While the ready queue is full, a due sleeping task stays in the sleep queue and `cmd_ready` stays 1. The task moves in the first cycle after a run command frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_op | input | 2 | 0 run, 1 configure, 2 add task, 3 preempt check |
| cmd_id | input | ID_W | Task identifier for add task |
| cmd_prio | input | PRIO_W | Task priority for add task |
| cmd_arg | input | TIME_W | Delay in ticks (add task) or clocks per tick (configure) |
| resp_valid | output | 1 | Response present, one cycle after acceptance |
| resp_id | output | ID_W | Dispatched task id (run) |
| resp_flag | output | 1 | Preempt flag (preempt check) |
| resp_err | output | 1 | Queue full on add, or empty ready queue on run |
| now_ticks | output | TIME_W | Elapsed ticks since the first run |

## Verification
The bench compares the block against a behavioural model on every clock. It feeds the model and the block bursts of immediate adds that mix unique and tied priorities, which separates a correct priority order from plain arrival order. It also sends delayed adds with equal and distinct wake times, which shows whether promotion follows wake order, moves only one task per cycle and blocks commands while it does so. Further patterns fill each queue to overflow, stall a due task behind a full ready queue, and change the tick length mid-run, including to zero. These expose off-by-one tick counting and flags computed against a stale running priority.

// File: rtl/sched_pkg.sv
// Shared definitions for the task scheduler: command opcodes.
// Assumes opcodes are carried on a 2-bit command field.
package sched_pkg;

    typedef enum logic [1:0] {
        OP_RUN    = 2'd0,
        OP_CONFIG = 2'd1,
        OP_ADD    = 2'd2,
        OP_CHECK  = 2'd3
    } sched_op_e;

endpackage

// File: rtl/sorted_queue.sv
// Small sorted register queue. Entries are held in key order: descending
// when ASCEND is 0, ascending when ASCEND is 1. Equal keys keep arrival
// order. One insert or one pop per cycle; the caller never asks for both,
// inserts into a full queue and pops of an empty queue are ignored.
module sorted_queue #(
    parameter int DEPTH  = 4,
    parameter int KEY_W  = 4,
    parameter int DATA_W = 4,
    parameter bit ASCEND = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic [KEY_W-1:0]  ins_key,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              pop_en,
    output logic              head_valid,
    output logic [KEY_W-1:0]  head_key,
    output logic [DATA_W-1:0] head_data,
    output logic              full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [KEY_W-1:0]  key_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [KEY_W-1:0]  key_n  [DEPTH];
    logic [DATA_W-1:0] data_n [DEPTH];
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  ahead;

    assign full       = (count_q == CNT_W'(DEPTH));
    assign head_valid = (count_q != '0);
    assign head_key   = key_q[0];
    assign head_data  = data_q[0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              prev_ahead;
        logic [KEY_W-1:0]  prev_key;
        logic [DATA_W-1:0] prev_data;
        logic [KEY_W-1:0]  nxt_key;
        logic [DATA_W-1:0] nxt_data;

        // Slot keeps its place in front of a newcomer with equal key
        if (ASCEND) begin : g_asc
            assign ahead[i] = (CNT_W'(i) < count_q) && (key_q[i] <= ins_key);
        end else begin : g_desc
            assign ahead[i] = (CNT_W'(i) < count_q) && (key_q[i] >= ins_key);
        end

        if (i == 0) begin : g_first
            assign prev_ahead = 1'b1;
            assign prev_key   = ins_key;
            assign prev_data  = ins_data;
        end else begin : g_rest
            assign prev_ahead = ahead[i-1];
            assign prev_key   = key_q[i-1];
            assign prev_data  = data_q[i-1];
        end

        if (i == DEPTH - 1) begin : g_last
            assign nxt_key  = key_q[i];
            assign nxt_data = data_q[i];
        end else begin : g_mid
            assign nxt_key  = key_q[i+1];
            assign nxt_data = data_q[i+1];
        end

        // Next content of this slot: shift down on pop, open a gap on insert
        always_comb begin
            key_n[i]  = key_q[i];
            data_n[i] = data_q[i];
            if (pop_en) begin
                key_n[i]  = nxt_key;
                data_n[i] = nxt_data;
            end else if (ins_en && !full && !ahead[i]) begin
                key_n[i]  = prev_ahead ? ins_key  : prev_key;
                data_n[i] = prev_ahead ? ins_data : prev_data;
            end
        end
    end

    // Register all slots and the occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                key_q[k]  <= '0;
                data_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                key_q[k]  <= key_n[k];
                data_q[k] <= data_n[k];
            end
            if (pop_en && head_valid)
                count_q <= count_q - 1'b1;
            else if (ins_en && !pop_en && !full)
                count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Elapsed-tick counter with a runtime-programmable prescaler. Counting
// begins after the first start pulse; a divisor load restarts the
// prescaler and takes precedence over counting in that cycle.
module tick_timer #(
    parameter int TIME_W  = 16,
    parameter int DEF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              div_load,
    input  logic [TIME_W-1:0] div_val,
    output logic [TIME_W-1:0] now
);
    logic              run_q;
    logic [TIME_W-1:0] div_q;
    logic [TIME_W-1:0] pre_q;

    // Prescale system clocks into ticks and count ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= TIME_W'(DEF_DIV);
            pre_q <= '0;
            now   <= '0;
        end else begin
            run_q <= run_q | start;
            if (div_load) begin
                div_q <= (div_val == '0) ? TIME_W'(1) : div_val;
                pre_q <= '0;
            end else if (run_q) begin
                if (pre_q == div_q - 1'b1) begin
                    pre_q <= '0;
                    now   <= now + 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/task_sched_core.sv
// Scheduling coprocessor top. Decodes one command per cycle, keeps a
// priority-ordered ready queue and a wake-time-ordered sleep queue, and
// moves due sleepers to the ready queue in hardware. A promotion owns
// both queues for its cycle, so commands are held off while one is due.
module task_sched_core #(
    parameter int ID_W    = 4,
    parameter int PRIO_W  = 4,
    parameter int TIME_W  = 16,
    parameter int DEPTH   = 4,
    parameter int DEF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [PRIO_W-1:0] cmd_prio,
    input  logic [TIME_W-1:0] cmd_arg,
    output logic              resp_valid,
    output logic [ID_W-1:0]   resp_id,
    output logic              resp_flag,
    output logic              resp_err,
    output logic [TIME_W-1:0] now_ticks
);
    import sched_pkg::*;

    localparam int SLP_DW = PRIO_W + ID_W;

    sched_op_e         op;
    logic              acc, promote;
    logic              add_now, add_later;
    logic              rdy_ins, rdy_pop, rdy_hv, rdy_full;
    logic [PRIO_W-1:0] rdy_ins_key, rdy_hkey;
    logic [ID_W-1:0]   rdy_ins_data, rdy_hdata;
    logic              slp_ins, slp_hv, slp_full;
    logic [TIME_W-1:0] slp_hkey;
    logic [SLP_DW-1:0] slp_hdata;
    logic              run_busy;
    logic [PRIO_W-1:0] run_prio;
    logic              preempt;

    assign op        = sched_op_e'(cmd_op);
    assign promote   = slp_hv && (slp_hkey <= now_ticks) && !rdy_full;
    assign cmd_ready = !promote;
    assign acc       = cmd_valid && cmd_ready;
    assign add_now   = acc && (op == OP_ADD) && (cmd_arg == '0);
    assign add_later = acc && (op == OP_ADD) && (cmd_arg != '0);

    // Ready queue feed: promotion or immediate add
    assign rdy_ins      = promote || (add_now && !rdy_full);
    assign rdy_ins_key  = promote ? slp_hdata[SLP_DW-1:ID_W] : cmd_prio;
    assign rdy_ins_data = promote ? slp_hdata[ID_W-1:0]      : cmd_id;
    assign rdy_pop      = acc && (op == OP_RUN) && rdy_hv;
    assign slp_ins      = add_later && !slp_full;

    assign preempt = rdy_hv && (!run_busy || (rdy_hkey > run_prio));

    tick_timer #(.TIME_W(TIME_W), .DEF_DIV(DEF_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(acc && (op == OP_RUN)),
        .div_load(acc && (op == OP_CONFIG)),
        .div_val(cmd_arg),
        .now(now_ticks)
    );

    sorted_queue #(.DEPTH(DEPTH), .KEY_W(PRIO_W), .DATA_W(ID_W), .ASCEND(1'b0)) u_ready (
        .clk(clk), .rst_n(rst_n),
        .ins_en(rdy_ins), .ins_key(rdy_ins_key), .ins_data(rdy_ins_data),
        .pop_en(rdy_pop),
        .head_valid(rdy_hv), .head_key(rdy_hkey), .head_data(rdy_hdata),
        .full(rdy_full)
    );

    sorted_queue #(.DEPTH(DEPTH), .KEY_W(TIME_W), .DATA_W(SLP_DW), .ASCEND(1'b1)) u_sleep (
        .clk(clk), .rst_n(rst_n),
        .ins_en(slp_ins), .ins_key(now_ticks + cmd_arg), .ins_data({cmd_prio, cmd_id}),
        .pop_en(promote),
        .head_valid(slp_hv), .head_key(slp_hkey), .head_data(slp_hdata),
        .full(slp_full)
    );

    // Track the priority of the task last handed to the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_busy <= 1'b0;
            run_prio <= '0;
        end else if (acc && (op == OP_RUN)) begin
            run_busy <= rdy_hv;
            run_prio <= rdy_hv ? rdy_hkey : '0;
        end
    end

    // Register the one-cycle command response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_id    <= '0;
            resp_flag  <= 1'b0;
            resp_err   <= 1'b0;
        end else begin
            resp_valid <= acc;
            resp_id    <= '0;
            resp_flag  <= 1'b0;
            resp_err   <= 1'b0;
            if (acc) begin
                unique case (op)
                    OP_RUN: begin
                        resp_id  <= rdy_hv ? rdy_hdata : '0;
                        resp_err <= !rdy_hv;
                    end
                    OP_CHECK: resp_flag <= preempt;
                    OP_ADD:   resp_err  <= (add_now && rdy_full) || (add_later && slp_full);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sched_checker.sv
// Temporal checks on the scheduler top, bound into every instance.
// Assumes the top's internal accept, opcode and queue-status names.
module sched_checker #(
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc,
    input logic [1:0]        cmd_op,
    input logic [TIME_W-1:0] cmd_arg,
    input logic              rdy_full,
    input logic              rdy_hv,
    input logic              resp_valid,
    input logic              resp_flag,
    input logic              resp_err,
    input logic [TIME_W-1:0] now_ticks
);
    // R9
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> resp_valid);
    // R9
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !resp_valid);
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(now_ticks) |-> now_ticks == $past(now_ticks) + 1'b1);
    // R6
    empty_run_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd0 && !rdy_hv) |=> resp_err);
    // R8
    full_add_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd2 && cmd_arg == '0 && rdy_full) |=> resp_err);
    // R7
    flag_only_on_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_flag |-> $past(acc && cmd_op == 2'd3));
endmodule

bind task_sched_core sched_checker #(.TIME_W(TIME_W)) u_sched_chk (
    .clk(clk), .rst_n(rst_n), .acc(acc), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .rdy_full(rdy_full), .rdy_hv(rdy_hv), .resp_valid(resp_valid),
    .resp_flag(resp_flag), .resp_err(resp_err), .now_ticks(now_ticks)
);

// File: tb/task_sched_core_bench.sv
// Bench: behavioural reference model stepped on every clock and compared
// with the scheduler's outputs on each falling edge.
module task_sched_core_bench;
    localparam int ID_W = 4, PRIO_W = 4, TIME_W = 16, DEPTH = 4, DEF_DIV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [1:0]        cmd_op = 2'd0;
    logic [ID_W-1:0]   cmd_id = '0;
    logic [PRIO_W-1:0] cmd_prio = '0;
    logic [TIME_W-1:0] cmd_arg = '0;
    logic              resp_valid, resp_flag, resp_err;
    logic [ID_W-1:0]   resp_id;
    logic [TIME_W-1:0] now_ticks;

    always #5 clk = ~clk;

    task_sched_core #(.ID_W(ID_W), .PRIO_W(PRIO_W), .TIME_W(TIME_W),
                      .DEPTH(DEPTH), .DEF_DIV(DEF_DIV)) u_task_sched_core (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_prio(cmd_prio), .cmd_arg(cmd_arg),
        .resp_valid(resp_valid), .resp_id(resp_id), .resp_flag(resp_flag),
        .resp_err(resp_err), .now_ticks(now_ticks)
    );

    typedef struct { int id; int prio; int wake; } ent_t;
    ent_t rq[$];
    ent_t sq[$];
    int m_now, m_div, m_pre, m_rprio;
    bit m_started, m_busy;
    bit m_rv, m_rf, m_re;
    int m_rid;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic bit m_promote();
        return sq.size() > 0 && sq[0].wake <= m_now && rq.size() < DEPTH;
    endfunction

    // Reference model: one step per rising edge
    always @(posedge clk) begin
        bit prom, acc;
        int now_old, pos;
        ent_t e;
        if (!rst_n) begin
            rq.delete(); sq.delete();
            m_now = 0; m_div = DEF_DIV; m_pre = 0; m_started = 0;
            m_busy = 0; m_rprio = 0; m_rv = 0; m_rid = 0; m_rf = 0; m_re = 0;
        end else begin
            prom = m_promote();
            acc = cmd_valid && !prom;
            now_old = m_now;
            m_rv = acc; m_rid = 0; m_rf = 0; m_re = 0;
            if (acc && cmd_op == 2'd1) begin
                m_div = (cmd_arg == 0) ? 1 : int'(cmd_arg);
                m_pre = 0;
            end else if (m_started) begin
                if (m_pre == m_div - 1) begin m_pre = 0; m_now++; end
                else m_pre++;
            end
            if (acc && cmd_op == 2'd0) m_started = 1;
            if (prom) begin
                e = sq.pop_front();
                pos = rq.size();
                for (int k = rq.size() - 1; k >= 0; k--) if (rq[k].prio < e.prio) pos = k;
                rq.insert(pos, e);
            end
            if (acc) begin
                case (cmd_op)
                    2'd0: if (rq.size() > 0) begin
                        e = rq.pop_front();
                        m_rid = e.id; m_busy = 1; m_rprio = e.prio;
                    end else begin
                        m_re = 1; m_busy = 0; m_rprio = 0;
                    end
                    2'd3: m_rf = rq.size() > 0 && (!m_busy || rq[0].prio > m_rprio);
                    2'd2: begin
                        e.id = int'(cmd_id); e.prio = int'(cmd_prio);
                        e.wake = (now_old + int'(cmd_arg)) % 65536;
                        if (cmd_arg == 0) begin
                            if (rq.size() < DEPTH) begin
                                pos = rq.size();
                                for (int k = rq.size() - 1; k >= 0; k--) if (rq[k].prio < e.prio) pos = k;
                                rq.insert(pos, e);
                            end else m_re = 1;
                        end else begin
                            if (sq.size() < DEPTH) begin
                                pos = sq.size();
                                for (int k = sq.size() - 1; k >= 0; k--) if (sq[k].wake > e.wake) pos = k;
                                sq.insert(pos, e);
                            end else m_re = 1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 resp_valid", int'(resp_valid), int'(m_rv));
            if (m_rv) begin
                chk("R4 R6 resp_id", int'(resp_id), m_rid);
                chk("R7 resp_flag", int'(resp_flag), int'(m_rf));
                chk("R6 R8 resp_err", int'(resp_err), int'(m_re));
            end
            chk("R5 R10 cmd_ready", int'(cmd_ready), int'(!m_promote()));
            chk("R2 R3 now_ticks", int'(now_ticks), m_now);
        end
    end

    // Issue one command; caller is at a falling edge
    task automatic send(int op, int id, int prio, int arg);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_id = id[ID_W-1:0];
        cmd_prio = prio[PRIO_W-1:0]; cmd_arg = arg[TIME_W-1:0];
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 resp_valid", int'(resp_valid), 0);
        chk("R1 cmd_ready", int'(cmd_ready), 1);
        chk("R1 now_ticks", int'(now_ticks), 0);
        idle(3);
        // R2 timer idle before first run; R4 ordering with ties; R8 ready full
        send(2, 1, 3, 0); send(2, 2, 7, 0); send(2, 3, 7, 0); send(2, 4, 1, 0);
        send(2, 5, 9, 0);
        send(3, 0, 0, 0);                  // R7 no running task
        idle(5);
        send(0, 0, 0, 0); send(3, 0, 0, 0); // R6 dispatch, R7 tie not preempt
        send(0, 0, 0, 0); send(0, 0, 0, 0); send(3, 0, 0, 0);
        send(0, 0, 0, 0); send(0, 0, 0, 0); // R6 empty run error
        idle(10);
        // R3 retune, R5 sleepers with equal and distinct wake times
        send(1, 0, 0, 2);
        send(2, 9, 4, 6); send(2, 6, 5, 5); send(2, 7, 2, 5); send(2, 8, 6, 4);
        send(2, 10, 8, 2);                 // R8 sleep full
        send(3, 0, 0, 0);
        idle(30);
        send(3, 0, 0, 0);
        // R10 stalled promotion behind full ready queue
        send(2, 11, 15, 1);
        idle(8);
        send(3, 0, 0, 0);
        send(0, 0, 0, 0);
        idle(3);
        send(3, 0, 0, 0);
        send(0, 0, 0, 0); send(0, 0, 0, 0);
        // R3 zero divisor acts as one
        send(1, 0, 0, 0);
        idle(12);
        send(1, 0, 0, 3);
        send(2, 12, 2, 2);
        idle(20);
        send(0, 0, 0, 0); send(0, 0, 0, 0); send(0, 0, 0, 0);
        send(0, 0, 0, 0); send(0, 0, 0, 0); send(0, 0, 0, 0);
        idle(4);
        report();
    end

endmodule